// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Run-Time Capacity and Write Policy

This block sits between the memory stage of a pipelined processor and a slower, word-addressed backing store of 64 words. Each cache block is a single word. Blocks are arranged as two-way sets. The capacity is picked when the block leaves reset and can be none, four words or eight words. The write policy is picked the same way and is either write-back or write-through. With no capacity, the block forwards every access to memory.

The processor side uses a request/ready handshake. The processor holds its request stable until ready is high, and the access completes at the clock edge that ends that cycle. A hit raises ready in the same cycle as the request. The memory side uses a request/done handshake with any latency. The memory raises done for one cycle when an operation finishes, and it returns read data in that same cycle.

On a miss the block chooses a way in the indexed set. In write-back mode it first writes out a dirty victim, then fetches the missing word and retries the access as a hit.

Top module: `cfg_assoc_cache`

## Requirements
- R1: While reset is high, the block samples the capacity code and the policy bit, invalidates every entry, clears every dirty flag and clears every replacement bit. After reset, with no request pending, ready and the memory request are both low.
- R2: The capacity code `cfg_size` selects the set count. Code 0 means no cache. Code 1 means 2 sets (4 words). Codes 2 and 3 mean 4 sets (8 words). The set index is the address modulo the set count, and an entry matches only when its stored full address equals the request address.
- R3: With no cache, each access makes exactly one memory operation of the same direction and address. Ready is high in the cycle where done is high, and read data is the word memory returns.
- R4: A read hit, or a write hit in write-back mode, raises ready in the same cycle as the request with no memory traffic. Read data is the stored word.
- R5: Once the memory request is raised, it stays high with an unchanged address and direction until done is seen.
- R6: A fill goes to way 0 if that way is invalid, otherwise to way 1 if that way is invalid, otherwise to the least recently used way. Every hit and every fill marks the touched way as most recently used.
- R7: In write-back mode a write hit updates the stored word, marks it dirty and causes no memory operation.
- R8: In write-back mode a miss whose victim is valid and dirty writes the victim's word to its own address before it reads the missing word. A write miss allocates the word and then completes as a dirty write hit.
- R9: In write-through mode every write makes one memory write, and ready is high in the cycle where done is high. A write hit also updates the stored word. A write miss allocates nothing.
- R10: A read miss installs the fetched word as a clean entry. The access then completes as a hit in the cycle after done.
- R11: Changes on the capacity and policy inputs while reset is low have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the configuration |
| cfg_size | input | 2 | Capacity code: 0 none, 1 four words, 2 or 3 eight words |
| cfg_wt | input | 1 | 1 selects write-through, 0 selects write-back |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 6 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes at the end of this cycle |
| cpu_rdata | output | 32 | Read data, valid while ready is high |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with done |
| mem_done | input | 1 | One-cycle completion pulse from memory |

## Verification
Some properties are checked on every cycle. The memory request must stay stable until it finishes. In the no-cache and write-through modes a completing write must coincide with memory completion. A write-back victim write must never complete a processor access. A hit that completes without memory completion must not be driving memory.

Other behaviour shows up only in the bench scenarios, where a behavioural model of sets, ways and replacement bits is compared against the design. These scenarios cover which way a fill replaces, whether a miss costs a victim write, whether write-through misses leave the cache untouched, that configuration changes after reset are ignored, and that the final backing-memory contents match.

// File: rtl/cache_pkg.sv
package cache_pkg;
   localparam int WAYS = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_PASS  = 2'd3
   } cache_st_e;

   typedef enum logic [1:0] {
      CAP_NONE  = 2'd0,
      CAP_HALF  = 2'd1,
      CAP_FULL  = 2'd2,
      CAP_FULL2 = 2'd3
   } cap_code_e;
endpackage

// File: rtl/cache_ways.sv
module cache_ways
   import cache_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int SETS   = 4,
   parameter int IDX_W  = $clog2(SETS)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [IDX_W-1:0]                 idx,
   input  logic [ADDR_W-1:0]                look_addr,
   input  logic                             wr_en,
   input  logic                             wr_way,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             wr_dirty,
   output logic [WAYS-1:0]                  valid_o,
   output logic [WAYS-1:0]                  dirty_o,
   output logic [WAYS-1:0]                  hit_o,
   output logic [WAYS-1:0][ADDR_W-1:0]      tag_o,
   output logic [WAYS-1:0][DATA_W-1:0]      data_o
);
   // one bank per way; the stored tag is the full word address
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]   vld_q;
      logic [SETS-1:0]   drt_q;
      logic [ADDR_W-1:0] tag_mem [SETS];
      logic [DATA_W-1:0] dat_mem [SETS];
      logic              we_w;

      assign we_w = wr_en && (wr_way == 1'(w));

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
         end else if (we_w) begin
            vld_q[idx] <= 1'b1;
            drt_q[idx] <= wr_dirty;
         end
      end

      always_ff @(posedge clk) begin
         if (we_w) begin
            tag_mem[idx] <= look_addr;
            dat_mem[idx] <= wr_data;
         end
      end

      assign valid_o[w] = vld_q[idx];
      assign dirty_o[w] = drt_q[idx];
      assign tag_o[w]   = tag_mem[idx];
      assign data_o[w]  = dat_mem[idx];
      assign hit_o[w]   = vld_q[idx] && (tag_mem[idx] == look_addr);
   end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int SETS  = 4,
   parameter int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             upd_en,
   input  logic             used_way,
   output logic             evict_way
);
   // per set: the way to replace next
   logic [SETS-1:0] lru_q;

   always_ff @(posedge clk) begin
      if (rst)         lru_q <= '0;
      else if (upd_en) lru_q[idx] <= ~used_way;
   end

   assign evict_way = lru_q[idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        bypass,
   input  logic                        wt,
   input  logic                        cpu_req,
   input  logic                        cpu_we,
   input  logic [ADDR_W-1:0]           cpu_addr,
   input  logic [DATA_W-1:0]           cpu_wdata,
   output logic                        cpu_ready,
   output logic [DATA_W-1:0]           cpu_rdata,
   output logic                        mem_req,
   output logic                        mem_we,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_wdata,
   input  logic [DATA_W-1:0]           mem_rdata,
   input  logic                        mem_done,
   input  logic [WAYS-1:0]             hit,
   input  logic [WAYS-1:0]             valid,
   input  logic [WAYS-1:0]             dirty,
   input  logic [WAYS-1:0][ADDR_W-1:0] tag,
   input  logic [WAYS-1:0][DATA_W-1:0] data,
   input  logic                        evict_way,
   output logic                        wr_en,
   output logic                        wr_way,
   output logic [DATA_W-1:0]           wr_data,
   output logic                        wr_dirty,
   output logic                        lru_upd,
   output logic                        lru_way
);
   cache_st_e st_q;
   logic      vic_q;
   logic      hit_any, hit_way, vic_pick, go_pass;

   assign hit_any  = |hit;
   assign hit_way  = hit[1];
   assign vic_pick = !valid[0] ? 1'b0 : (!valid[1] ? 1'b1 : evict_way);
   assign go_pass  = bypass || (wt && cpu_we);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         vic_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cpu_req) begin
               if (go_pass) st_q <= ST_PASS;
               else if (!hit_any) begin
                  vic_q <= vic_pick;
                  st_q  <= (!wt && valid[vic_pick] && dirty[vic_pick]) ? ST_EVICT : ST_FILL;
               end
            end
            ST_EVICT: if (mem_done) st_q <= ST_FILL;
            ST_FILL:  if (mem_done) st_q <= ST_IDLE;
            ST_PASS:  if (mem_done) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cpu_ready = 1'b0;
      cpu_rdata = data[hit_way];
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
      wr_en     = 1'b0;
      wr_way    = hit_way;
      wr_data   = cpu_wdata;
      wr_dirty  = 1'b0;
      lru_upd   = 1'b0;
      lru_way   = hit_way;
      unique case (st_q)
         ST_IDLE: if (cpu_req && !go_pass && hit_any) begin
            cpu_ready = 1'b1;
            lru_upd   = 1'b1;
            if (cpu_we) begin
               wr_en    = 1'b1;
               wr_dirty = 1'b1;
            end
         end
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tag[vic_q];
            mem_wdata = data[vic_q];
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_done) begin
               wr_en   = 1'b1;
               wr_way  = vic_q;
               wr_data = mem_rdata;
               lru_upd = 1'b1;
               lru_way = vic_q;
            end
         end
         ST_PASS: begin
            mem_req   = 1'b1;
            mem_we    = cpu_we;
            cpu_rdata = mem_rdata;
            if (mem_done) begin
               cpu_ready = 1'b1;
               if (!bypass && cpu_we && hit_any) begin
                  wr_en   = 1'b1;
                  lru_upd = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cfg_assoc_cache.sv
module cfg_assoc_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int MAX_SETS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cfg_size,
   input  logic              cfg_wt,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done
);
   localparam int IDX_W = $clog2(MAX_SETS);

   if (MAX_SETS < 2 || (MAX_SETS & (MAX_SETS - 1)) != 0) begin : g_bad_sets
      $error("MAX_SETS must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [1:0] size_q;
   logic       wt_q;
   logic       bypass_q;

   // configuration is captured only while reset is held
   always_ff @(posedge clk) begin
      if (rst) begin
         size_q <= cfg_size;
         wt_q   <= cfg_wt;
      end
   end

   assign bypass_q = (size_q == CAP_NONE);

   logic [IDX_W-1:0] half_mask, set_mask, idx;
   if (IDX_W == 1) begin : g_mask_one
      assign half_mask = '0;
   end else begin : g_mask_wide
      assign half_mask = {1'b0, {(IDX_W-1){1'b1}}};
   end
   assign set_mask = (size_q == CAP_HALF) ? half_mask : {IDX_W{1'b1}};
   assign idx      = cpu_addr[IDX_W-1:0] & set_mask;

   logic [WAYS-1:0]             valid, dirty, hit;
   logic [WAYS-1:0][ADDR_W-1:0] tag;
   logic [WAYS-1:0][DATA_W-1:0] data;
   logic                        wr_en, wr_way, wr_dirty, lru_upd, lru_way, evict_way;
   logic [DATA_W-1:0]           wr_data;

   cache_ways #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(MAX_SETS)) u_ways (
      .clk(clk), .rst(rst), .idx(idx), .look_addr(cpu_addr),
      .wr_en(wr_en), .wr_way(wr_way), .wr_data(wr_data), .wr_dirty(wr_dirty),
      .valid_o(valid), .dirty_o(dirty), .hit_o(hit), .tag_o(tag), .data_o(data)
   );

   cache_lru #(.SETS(MAX_SETS)) u_lru (
      .clk(clk), .rst(rst), .idx(idx), .upd_en(lru_upd), .used_way(lru_way),
      .evict_way(evict_way)
   );

   cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst(rst), .bypass(bypass_q), .wt(wt_q),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done),
      .hit(hit), .valid(valid), .dirty(dirty), .tag(tag), .data(data), .evict_way(evict_way),
      .wr_en(wr_en), .wr_way(wr_way), .wr_data(wr_data), .wr_dirty(wr_dirty),
      .lru_upd(lru_upd), .lru_way(lru_way)
   );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_done,
   input logic              bypass,
   input logic              wt
);
   assert_mem_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_bypass_done_R3: assert property (@(posedge clk) disable iff (rst)
      (bypass && cpu_ready) |-> mem_done);

   assert_wt_write_R9: assert property (@(posedge clk) disable iff (rst)
      (!bypass && wt && cpu_req && cpu_we && cpu_ready) |-> (mem_done && mem_we));

   assert_victim_write_R8: assert property (@(posedge clk) disable iff (rst)
      (!bypass && !wt && mem_req && mem_we) |-> !cpu_ready);

   assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      (!bypass && cpu_ready && !mem_done) |-> !mem_req);
endmodule

bind cfg_assoc_cache cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_done(mem_done),
   .bypass(bypass_q), .wt(wt_q)
);

// File: tb/sim_cfg_assoc_cache.sv
module sim_cfg_assoc_cache;
   localparam int AW = 6;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cfg_size = 2'd0;
   logic          cfg_wt = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_done = 1'b0;

   always #10 clk = ~clk;

   cfg_assoc_cache u0 (
      .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_wt(cfg_wt),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   // backing memory, latency 1..3 cycles by address
   logic [DW-1:0] bmem [64];
   int            cnt = 0, n_rd = 0, n_wr = 0;
   always @(posedge clk) begin
      if (rst) begin
         mem_done <= 1'b0;
         cnt      <= 0;
         for (int i = 0; i < 64; i++) bmem[i] <= DW'(i * 7 + 3);
      end else begin
         mem_done <= 1'b0;
         if (mem_req && !mem_done) begin
            if (cnt >= int'(mem_addr) % 3) begin
               mem_done  <= 1'b1;
               cnt       <= 0;
               mem_rdata <= bmem[mem_addr];
               if (mem_we) begin
                  bmem[mem_addr] <= mem_wdata;
                  n_wr <= n_wr + 1;
               end else n_rd <= n_rd + 1;
            end else cnt <= cnt + 1;
         end
      end
   end

   int checks = 0, failures = 0;
   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // every clock: no completion without a request
   bit run_on = 1'b0;
   always @(negedge clk) begin
      if (run_on && !rst) chk(!(cpu_ready && !cpu_req), "R1", "ready without request", int'(cpu_ready), 0);
   end

   // behavioural reference
   int m_valid[4][2], m_dirty[4][2], m_addr[4][2], m_data[4][2], m_lru[4];
   int model_mem[64];
   int m_sets;
   bit m_byp, m_wt;
   string ovr = "";
   int unsigned seed = 32'd12345;

   task automatic do_reset(int size, bit wt);
      @(negedge clk);
      run_on = 1'b0; rst = 1'b1; cpu_req = 1'b0;
      cfg_size = 2'(size); cfg_wt = wt;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int s = 0; s < 4; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < 2; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; end
      end
      for (int i = 0; i < 64; i++) model_mem[i] = i * 7 + 3;
      m_byp  = (size == 0);
      m_sets = (size == 0) ? 1 : (size == 1 ? 2 : 4);
      m_wt   = wt;
      #1;
      chk(cpu_ready == 1'b0, "R1", "ready after reset", int'(cpu_ready), 0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
      run_on = 1'b1;
   endtask

   task automatic access(bit we, int addr, int wdata);
      int    idx, hw, v, exp_rd, exp_wr, exp_data, waits, rd0, wr0, got;
      bit    exp_hit;
      string tag;
      exp_rd = 0; exp_wr = 0; exp_data = 0; exp_hit = 0; hw = -1;
      idx = addr % m_sets;
      if (m_byp) begin
         tag = "R3";
         if (we) begin exp_wr = 1; model_mem[addr] = wdata; end
         else begin exp_rd = 1; exp_data = model_mem[addr]; end
      end else begin
         for (int w = 0; w < 2; w++) if (m_valid[idx][w] != 0 && m_addr[idx][w] == addr) hw = w;
         if (we && m_wt) begin
            tag = "R9"; exp_wr = 1; model_mem[addr] = wdata;
            if (hw >= 0) begin m_data[idx][hw] = wdata; m_lru[idx] = 1 - hw; end
         end else if (hw >= 0) begin
            tag = we ? "R7" : "R4"; exp_hit = 1; m_lru[idx] = 1 - hw;
            if (we) begin m_data[idx][hw] = wdata; m_dirty[idx][hw] = 1; end
            else exp_data = m_data[idx][hw];
         end else begin
            tag = we ? "R8" : "R10";
            v = (m_valid[idx][0] == 0) ? 0 : ((m_valid[idx][1] == 0) ? 1 : m_lru[idx]);
            if (!m_wt && m_valid[idx][v] != 0 && m_dirty[idx][v] != 0) begin
               exp_wr = 1; model_mem[m_addr[idx][v]] = m_data[idx][v];
            end
            exp_rd = 1;
            m_valid[idx][v] = 1; m_addr[idx][v] = addr; m_data[idx][v] = model_mem[addr];
            m_dirty[idx][v] = 0; m_lru[idx] = 1 - v;
            if (we) begin m_data[idx][v] = wdata; m_dirty[idx][v] = 1; end
            else exp_data = m_data[idx][v];
         end
      end
      if (ovr != "") tag = ovr;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(wdata);
      rd0 = n_rd; wr0 = n_wr; waits = 0;
      #1;
      while (!cpu_ready && waits < 100) begin
         @(negedge clk); #1; waits++;
      end
      got = int'(cpu_rdata);
      chk(waits < 100, tag, "access timed out", waits, 0);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      if (!we) chk(got == exp_data, tag, "read data", got, exp_data);
      chk(n_rd - rd0 == exp_rd, tag, "memory reads", n_rd - rd0, exp_rd);
      chk(n_wr - wr0 == exp_wr, tag, "memory writes", n_wr - wr0, exp_wr);
      if (exp_hit) chk(waits == 0, tag, "hit wait cycles", waits, 0);
      else chk(waits > 0, tag, "miss/pass wait cycles", waits, 1);
   endtask

   task automatic rand_run(int n);
      for (int k = 0; k < n; k++) begin
         int unsigned r;
         seed = seed * 32'd1103515245 + 32'd12345;
         r = seed >> 16;
         access(r[4], int'(r % 16), int'(r % 100));
      end
   endtask

   task automatic mem_compare(string tag);
      @(negedge clk);
      for (int i = 0; i < 64; i++) chk(int'(bmem[i]) == model_mem[i], tag, "backing word", int'(bmem[i]), model_mem[i]);
   endtask

   initial begin
      // watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // write-back, eight words: replacement order R6, config freeze R11
      do_reset(2, 1'b0);
      ovr = "R6";
      access(0, 0, 0); access(0, 4, 0); access(0, 0, 0);
      access(0, 8, 0); access(0, 0, 0); access(0, 4, 0);
      ovr = "R7";
      access(1, 0, 55); access(0, 0, 0);
      ovr = "R11";
      cfg_size = 2'd0; cfg_wt = 1'b1;
      access(0, 0, 0); access(1, 0, 66); access(0, 0, 0);
      cfg_size = 2'd2; cfg_wt = 1'b0;
      ovr = "R8";
      access(0, 12, 0);
      ovr = "";
      rand_run(50);
      mem_compare("R8");

      // write-back, four words: two-set indexing R2
      do_reset(1, 1'b0);
      ovr = "R2";
      access(0, 1, 0); access(0, 3, 0); access(0, 5, 0); access(0, 1, 0); access(0, 3, 0);
      ovr = "";
      rand_run(50);
      mem_compare("R7");

      // write-through, eight words: no allocate R9
      do_reset(2, 1'b1);
      ovr = "R9";
      access(1, 9, 21); access(0, 9, 0); access(0, 9, 0); access(1, 9, 22); access(0, 9, 0);
      ovr = "";
      rand_run(50);
      mem_compare("R9");

      do_reset(1, 1'b1);
      rand_run(40);
      mem_compare("R9");

      // no cache R3
      do_reset(0, 1'b0);
      rand_run(30);
      mem_compare("R3");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule